// File: doc/BRIEF.md
# Serial-Access Nonvolatile Memory Front End

This block models a small user nonvolatile store whose words are reached only through two serial registers. A 9-bit address register runs on its own slow strobe. On each strobe it either takes one serial bit or steps to the next word. A 16-bit data register has a strobe of its own. On each strobe it either takes one serial bit into its top bit or loads the word at the current address. Its top bit is the only serial output. Both strobes are asynchronous to the system clock. They are synchronised, and their rising edges are detected in the system clock domain.

A rising edge on the program request ANDs the data register into the addressed word, because programming can only clear bits. A rising edge on the erase request sets to all ones every word of the half of the store selected by the address MSB. Each operation holds `busy` high for a fixed number of system clocks. While `busy` is high, both registers are frozen and new requests are dropped, not queued. An in-system-programming lock input blocks every register and command action while it is high. A gated, divided oscillator output is also provided for user logic.

Top module: `sermem_front`

## Requirements
- R1: On an address strobe edge with `adr_shift` high, the address shifts left one place and takes `adr_din` as its new LSB, so nine strobes load a value MSB first. With `adr_shift` low, the address increments by one.
- R2: Incrementing the address from 511 wraps it to 0.
- R3: A program request edge replaces the addressed word with (word AND data register), so programming never sets a bit.
- R4: An erase request edge sets to 0xFFFF every word whose address MSB equals the address register MSB. Words in the other sector are left untouched.
- R5: On a data strobe edge with `dat_shift` high, the register shifts right and `dat_din` enters its MSB, so `dat_dout` shows the bit just shifted in. Sixteen strobes taking the LSB first load a value.
- R6: On a data strobe edge with `dat_shift` low, the register loads the word at the current address, and `dat_dout` shows that word's MSB.
- R7: `busy` rises only after an accepted command. It stays high for PROG_CYC system clocks after a program and for ERASE_CYC system clocks after an erase (defaults 40 and 200).
- R8: While `busy` is high, address strobes, data strobes and command edges have no effect, and a dropped command does not run once `busy` falls.
- R9: While `isp_lock` is high, no address shift, increment, data shift, load, program or erase takes effect, and `busy` does not rise.
- R10: With `osc_en` low, `osc_out` is held low. With it high, `osc_out` toggles every OSC_DIV system clocks (default 4) and starts low.
- R11: After reset, every word reads 0xFFFF, the address is 0, the data register is 0, and `busy` and `osc_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adr_clk | input | 1 | Address register strobe (asynchronous) |
| adr_shift | input | 1 | 1 = shift address, 0 = increment |
| adr_din | input | 1 | Serial address bit |
| dat_clk | input | 1 | Data register strobe (asynchronous) |
| dat_shift | input | 1 | 1 = shift data, 0 = load addressed word |
| dat_din | input | 1 | Serial data bit |
| prog_req | input | 1 | Program request, rising edge active |
| erase_req | input | 1 | Sector erase request, rising edge active |
| osc_en | input | 1 | Oscillator enable |
| isp_lock | input | 1 | In-system-programming lockout, blocks all actions |
| dat_dout | output | 1 | Data register MSB |
| busy | output | 1 | Program or erase in progress |
| osc_out | output | 1 | Divided oscillator output |

## Verification
A wrong address or a wrongly stored word shows up only at `dat_dout`, on the load strobe that follows. Each check therefore arranges for the MSB of the targeted word to differ from the MSB of its neighbours. An off-by-one address or a leaked write then flips the bit seen within three system clocks of that strobe. A wrong busy count shows up as a `busy` pulse of the wrong length, which is measured cycle by cycle. A command that was wrongly queued or accepted shows up as a second `busy` pulse, or as a changed word on the next read.

// File: rtl/smf_pkg.sv
package smf_pkg;
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_PROG  = 2'd1,
      CMD_ERASE = 2'd2
   } cmd_e;
endpackage

// File: rtl/smf_sync.sv
module smf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/smf_edge.sv
module smf_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   logic lvl, prev;

   smf_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst_n(rst_n), .d(d), .q(lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/smf_addr.sv
module smf_addr #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              shift,
   input  logic              din,
   input  logic              hold,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (step && !hold) begin
         if (shift) addr <= {addr[ADDR_W-2:0], din};
         else       addr <= addr + 1'b1;
      end
   end
endmodule

// File: rtl/smf_store.sv
module smf_store
   import smf_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 16,
   parameter int PROG_CYC  = 40,
   parameter int ERASE_CYC = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dat_step,
   input  logic              dat_shift,
   input  logic              dat_din,
   input  logic              prog_rise,
   input  logic              erase_rise,
   input  logic              lock,
   output logic              dout,
   output logic              busy
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HALF  = DEPTH / 2;
   localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW    = $clog2(MAXC + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] dreg;
   logic [CW-1:0]     cnt;
   cmd_e              cmd;
   logic              accept;

   assign cmd    = prog_rise  ? CMD_PROG  :
                   erase_rise ? CMD_ERASE : CMD_NONE;
   assign busy   = (cnt != '0);
   assign accept = !busy && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (busy)
         cnt <= cnt - 1'b1;
      else if (accept && cmd == CMD_PROG)
         cnt <= CW'(PROG_CYC);
      else if (accept && cmd == CMD_ERASE)
         cnt <= CW'(ERASE_CYC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (accept && cmd == CMD_PROG) begin
         mem[addr] <= mem[addr] & dreg;
      end else if (accept && cmd == CMD_ERASE) begin
         for (int i = 0; i < HALF; i++)
            mem[{addr[ADDR_W-1], (ADDR_W-1)'(i)}] <= '1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dreg <= '0;
      else if (dat_step && accept) begin
         if (dat_shift) dreg <= {dat_din, dreg[DATA_W-1:1]};
         else           dreg <= mem[addr];
      end
   end

   assign dout = dreg[DATA_W-1];
endmodule

// File: rtl/smf_osc.sv
module smf_osc #(
   parameter int OSC_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic osc
);
   generate
      if (OSC_DIV == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   osc <= 1'b0;
            else if (!en) osc <= 1'b0;
            else          osc <= ~osc;
         end
      end else begin : g_count
         localparam int DW = $clog2(OSC_DIV);
         logic [DW-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div <= '0;
               osc <= 1'b0;
            end else if (!en) begin
               div <= '0;
               osc <= 1'b0;
            end else if (div == DW'(OSC_DIV - 1)) begin
               div <= '0;
               osc <= ~osc;
            end else begin
               div <= div + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sermem_front.sv
module sermem_front #(
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 16,
   parameter int PROG_CYC  = 40,
   parameter int ERASE_CYC = 200,
   parameter int OSC_DIV   = 4,
   parameter int SYNC_STG  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adr_clk,
   input  logic adr_shift,
   input  logic adr_din,
   input  logic dat_clk,
   input  logic dat_shift,
   input  logic dat_din,
   input  logic prog_req,
   input  logic erase_req,
   input  logic osc_en,
   input  logic isp_lock,
   output logic dat_dout,
   output logic busy,
   output logic osc_out
);
   localparam int N_EDGE = 4;
   localparam int N_LVL  = 6;

   generate
      if (ADDR_W < 2 || DATA_W < 2 || PROG_CYC < 1 || ERASE_CYC < 1 ||
          OSC_DIV < 1 || SYNC_STG < 2) begin : g_bad_cfg
         $error("sermem_front: illegal parameter set");
      end
   endgenerate

   logic [N_EDGE-1:0] edge_in, edge_rise;
   logic [N_LVL-1:0]  lvl_in, lvl_q;

   assign edge_in = {erase_req, prog_req, dat_clk, adr_clk};
   assign lvl_in  = {isp_lock, osc_en, dat_din, dat_shift, adr_din, adr_shift};

   genvar gi;
   generate
      for (gi = 0; gi < N_EDGE; gi++) begin : g_edge
         smf_edge #(.STAGES(SYNC_STG)) u_edge (
            .clk(clk), .rst_n(rst_n), .d(edge_in[gi]), .rise(edge_rise[gi]));
      end
      for (gi = 0; gi < N_LVL; gi++) begin : g_lvl
         smf_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(lvl_in[gi]), .q(lvl_q[gi]));
      end
   endgenerate

   logic adr_rise, dat_rise, prog_rise, erase_rise;
   logic adr_shift_lvl, adr_din_lvl, dat_shift_lvl, dat_din_lvl, osc_lvl, lock_lvl;
   logic [ADDR_W-1:0] addr_q;

   assign {erase_rise, prog_rise, dat_rise, adr_rise} = edge_rise;
   assign {lock_lvl, osc_lvl, dat_din_lvl, dat_shift_lvl, adr_din_lvl, adr_shift_lvl} = lvl_q;

   smf_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .step(adr_rise), .shift(adr_shift_lvl),
      .din(adr_din_lvl), .hold(busy | lock_lvl), .addr(addr_q));

   smf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC),
               .ERASE_CYC(ERASE_CYC)) u_store (
      .clk(clk), .rst_n(rst_n), .addr(addr_q), .dat_step(dat_rise),
      .dat_shift(dat_shift_lvl), .dat_din(dat_din_lvl), .prog_rise(prog_rise),
      .erase_rise(erase_rise), .lock(lock_lvl), .dout(dat_dout), .busy(busy));

   smf_osc #(.OSC_DIV(OSC_DIV)) u_osc (
      .clk(clk), .rst_n(rst_n), .en(osc_lvl), .osc(osc_out));
endmodule

// File: rtl/smf_front_chk.sv
module smf_front_chk #(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              prog_rise,
   input logic              erase_rise,
   input logic              dat_rise,
   input logic              dat_shift_lvl,
   input logic              dat_din_lvl,
   input logic              lock_lvl,
   input logic              osc_lvl,
   input logic              osc_out,
   input logic              dat_dout,
   input logic [ADDR_W-1:0] addr_q
);
   p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(prog_rise || erase_rise));

   p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));

   p_dout_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(dat_dout));

   p_lock_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_lvl && !busy) |=> !busy);

   p_lock_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_lvl |=> ($stable(addr_q) && $stable(dat_dout)));

   p_dout_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rise && dat_shift_lvl && !busy && !lock_lvl) |=> (dat_dout == $past(dat_din_lvl)));

   p_osc_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_lvl |=> !osc_out);
endmodule

bind sermem_front smf_front_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .prog_rise(prog_rise),
   .erase_rise(erase_rise), .dat_rise(dat_rise), .dat_shift_lvl(dat_shift_lvl),
   .dat_din_lvl(dat_din_lvl), .lock_lvl(lock_lvl), .osc_lvl(osc_lvl),
   .osc_out(osc_out), .dat_dout(dat_dout), .addr_q(addr_q));

// File: tb/tb_sermem_front.sv
`timescale 1ns/1ps
module tb_sermem_front;
   localparam int PROG_CYC  = 40;
   localparam int ERASE_CYC = 200;
   localparam int OSC_DIV   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adr_clk = 0, adr_shift = 0, adr_din = 0;
   logic dat_clk = 0, dat_shift = 0, dat_din = 0;
   logic prog_req = 0, erase_req = 0, osc_en = 0, isp_lock = 0;
   logic dat_dout, busy, osc_out;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   sermem_front #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .OSC_DIV(OSC_DIV)) dut (
      .clk(clk), .rst_n(rst_n), .adr_clk(adr_clk), .adr_shift(adr_shift),
      .adr_din(adr_din), .dat_clk(dat_clk), .dat_shift(dat_shift), .dat_din(dat_din),
      .prog_req(prog_req), .erase_req(erase_req), .osc_en(osc_en), .isp_lock(isp_lock),
      .dat_dout(dat_dout), .busy(busy), .osc_out(osc_out));

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_adr;
      adr_clk = 1; wait_n(4); adr_clk = 0; wait_n(4);
   endtask

   task automatic pulse_dat;
      dat_clk = 1; wait_n(4); dat_clk = 0; wait_n(4);
   endtask

   task automatic set_addr(input int a);
      adr_shift = 1;
      for (int b = 8; b >= 0; b--) begin
         adr_din = a[b];
         pulse_adr();
      end
      adr_shift = 0;
   endtask

   task automatic incr_addr;
      adr_shift = 0; pulse_adr();
   endtask

   task automatic set_data(input int v);
      dat_shift = 1;
      for (int b = 0; b < 16; b++) begin
         dat_din = v[b];
         pulse_dat();
      end
      dat_shift = 0;
   endtask

   task automatic load;
      dat_shift = 0; pulse_dat();
   endtask

   // raises prog (kind 0) or erase (kind 1) and counts busy-high samples
   task automatic cmd_count(input int kind, output int n);
      n = 0;
      if (kind == 0) prog_req = 1; else erase_req = 1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == 4) begin prog_req = 0; erase_req = 0; end
         if (busy) n++;
         else if (n > 0) break;
      end
      prog_req = 0; erase_req = 0;
      wait_n(4);
   endtask

   task automatic program_word(input int a, input int v, input string tag);
      int n;
      set_addr(a);
      set_data(v);
      cmd_count(0, n);
      check({tag, " busy length program R7"}, n, PROG_CYC);
   endtask

   task automatic read_msb(input int a, input int exp, input string tag);
      set_addr(a);
      load();
      check(tag, int'(dat_dout), exp);
   endtask

   task automatic t_reset;
      check("R11 busy after reset", int'(busy), 0);
      check("R11 osc after reset", int'(osc_out), 0);
      check("R11 dout after reset", int'(dat_dout), 0);
      load();
      check("R11 word 0 erased at reset", int'(dat_dout), 1);
   endtask

   task automatic t_shift_out;
      dat_shift = 1;
      dat_din = 1; pulse_dat();
      check("R5 dout shows shifted 1", int'(dat_dout), 1);
      dat_din = 0; pulse_dat();
      check("R5 dout shows shifted 0", int'(dat_dout), 0);
      dat_din = 1; pulse_dat();
      check("R5 dout shows shifted 1 again", int'(dat_dout), 1);
      dat_shift = 0;
   endtask

   task automatic t_program;
      program_word(9'h0A5, 16'h7FFF, "R3");
      read_msb(9'h0A5, 0, "R6 R1 programmed word MSB");
      incr_addr();
      load();
      check("R1 increment to neighbour reads erased", int'(dat_dout), 1);
      read_msb(9'h0A4, 1, "R1 lower neighbour erased");
   endtask

   task automatic t_and;
      program_word(9'h0A5, 16'hFFFF, "R3 and");
      read_msb(9'h0A5, 0, "R3 program cannot set bits");
   endtask

   task automatic t_wrap;
      program_word(9'h000, 16'h0000, "R2");
      read_msb(9'h1FF, 1, "R2 top word erased");
      incr_addr();
      load();
      check("R2 increment from 511 wraps to 0", int'(dat_dout), 0);
   endtask

   task automatic t_erase;
      int n;
      program_word(9'h1F0, 16'h0000, "R4");
      read_msb(9'h1F0, 0, "R4 sector1 word programmed");
      set_addr(9'h100);
      cmd_count(1, n);
      check("R7 busy length erase", n, ERASE_CYC);
      read_msb(9'h1F0, 1, "R4 sector1 word erased");
      read_msb(9'h0A5, 0, "R4 sector0 word untouched");
      read_msb(9'h000, 0, "R4 sector0 word 0 untouched");
   endtask

   task automatic t_busy_ignore;
      int seen;
      set_addr(9'h0A5);
      set_data(16'hFFFF);
      prog_req = 1; wait_n(4); prog_req = 0;
      check("R8 busy running", int'(busy), 1);
      adr_shift = 0; pulse_adr();
      erase_req = 1; wait_n(4); erase_req = 0; wait_n(4);
      dat_shift = 1; dat_din = 0; pulse_dat(); dat_shift = 0;
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
      seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (busy) seen = 1;
      end
      check("R8 dropped erase not queued", seen, 0);
      check("R8 data shift ignored during busy", int'(dat_dout), 1);
      load();
      check("R8 address unchanged, sector not erased", int'(dat_dout), 0);
   endtask

   task automatic t_lock;
      int seen;
      set_data(16'h0000);
      set_addr(9'h1F0);
      isp_lock = 1; wait_n(4);
      seen = 0;
      prog_req = 1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (i == 4) prog_req = 0;
         if (busy) seen = 1;
      end
      check("R9 busy stays low under lock", seen, 0);
      dat_shift = 1; dat_din = 1; pulse_dat(); dat_shift = 0;
      check("R9 data shift blocked", int'(dat_dout), 0);
      incr_addr();
      isp_lock = 0; wait_n(4);
      load();
      check("R9 word not programmed, address not stepped", int'(dat_dout), 1);
   endtask

   task automatic t_osc;
      int hi, tog;
      logic prev;
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (osc_out) hi++;
      end
      check("R10 osc low while disabled", hi, 0);
      osc_en = 1;
      wait_n(8);
      tog = 0;
      prev = osc_out;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (osc_out != prev) tog++;
         prev = osc_out;
      end
      check("R10 toggles every OSC_DIV clocks", tog, 64 / OSC_DIV);
      osc_en = 0;
      wait_n(4);
      check("R10 osc low after disable", int'(osc_out), 0);
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      wait_n(5);
      rst_n = 1;
      wait_n(3);
      t_reset();
      t_shift_out();
      t_program();
      t_and();
      t_wrap();
      t_erase();
      t_busy_ignore();
      t_lock();
      t_osc();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule